// File: doc/BRIEF.md
# Split-Word Register Access Bridge

This block lets a host that only has a 32-bit register port reach a bank of 64-bit engine registers. The host stages a 64-bit value in two 32-bit data words, then writes a command word. Bit 31 of the command picks the direction: set means write, clear means read. Bits 30:0 carry the engine address. The command is accepted only if no earlier access is still outstanding. If its address falls inside the engine window, it goes out on a 64-bit request/acknowledge port. A read's returned value lands back in the two data words, where the host can fetch it high word first.

Problems are recorded in a sticky status word. Bit 31 is a summary flag that the host tests after each command. Two causes are recorded:
- an address outside the window, which is never forwarded;
- a command issued while the port is still busy, which is dropped.

A write of any value to the clear offset wipes the status and abandons an outstanding access. Any acknowledge that arrives after that is ignored. An optional interrupt output mirrors the summary flag once it is enabled.

Top module: `split_word_bridge`

## Requirements
- R1: After reset, every host offset reads 0, `eng_req` is 0 and `irq` is 0.
- R2: Host writes to offset 0x00 (high word) and 0x04 (low word) read back unchanged. Offsets with no register read 0.
- R3: A command (offset 0x08) with bit 31 set and an address in [ENG_BASE, ENG_BASE+ENG_SPAN) sets `eng_req` from the next cycle. In that cycle `eng_we`=1, `eng_addr`=address−ENG_BASE and `eng_wdata`={high,low}. The request is held until the cycle in which `eng_ack` is sampled high.
- R4: An in-range command with bit 31 clear issues a request with `eng_we`=0. When it is acknowledged, the high word becomes `eng_rdata[63:32]` and the low word becomes `eng_rdata[31:0]`.
- R5: Status bit 0 (offset 0x1C) reads 1 from the cycle after an accepted in-range command until the cycle after its acknowledge.
- R6: An accepted command with an address outside the window raises no request and sets status bits 31 and 1.
- R7: A command written while an access is outstanding is dropped and sets status bits 31 and 2. The outstanding access continues unchanged.
- R8: Offset 0x08 reads back the last command that was not dropped for being busy.
- R9: Error bits stay set through later successful commands.
- R10: Any write to offset 0x18 clears the status, drops `eng_req` on the next cycle, and makes a later acknowledge have no effect on the data words.
- R11: Offset 0x20 bit 0 is an interrupt enable that reads back. `irq` is 1 exactly when the enable and status bit 31 are both 1.
- R12: Once a write request has been issued, `eng_addr`, `eng_we` and `eng_wdata` hold steady until it completes, even if the host rewrites the data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| eng_req | output | 1 | Downstream request, held until acknowledged |
| eng_we | output | 1 | Downstream direction, 1 = write |
| eng_addr | output | ENG_AW | Downstream register address, relative to the window base |
| eng_wdata | output | 64 | Downstream write value |
| eng_ack | input | 1 | Downstream completion |
| eng_rdata | input | 64 | Downstream read value, valid with `eng_ack` |
| irq | output | 1 | Error interrupt |

## Verification
A wrong launch decision shows on `eng_req` one cycle after the command write. A wrongly latched address or write value shows on `eng_addr` and `eng_wdata` in that same cycle, and stays visible for as long as the request is held. A busy flag that sticks or clears early shows at status bit 0 on the first read after the acknowledge. In that case a following command is also wrongly rejected or wrongly accepted. A lost sticky bit, or an abort that fails to take hold, becomes visible on the next status read or when the late acknowledge lands in the data words.

// File: rtl/sw_bridge_pkg.sv
package sw_bridge_pkg;

    localparam int WORD_W = 32;
    localparam int WIDE_W = 2 * WORD_W;

    // host byte offsets
    localparam logic [7:0] OFS_DHI  = 8'h00;
    localparam logic [7:0] OFS_DLO  = 8'h04;
    localparam logic [7:0] OFS_CMD  = 8'h08;
    localparam logic [7:0] OFS_CLR  = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h1C;
    localparam logic [7:0] OFS_IEN  = 8'h20;

    // status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_RANGE = 1;
    localparam int ST_COLL  = 2;
    localparam int ST_SUM   = 31;

    typedef struct packed {
        logic        write;
        logic [30:0] addr;
    } cmd_t;

    typedef struct packed {
        logic range_bad;
        logic collided;
    } err_t;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_WAIT = 1'b1
    } port_state_e;

    function automatic logic addr_in_window(input logic [30:0] a,
                                            input logic [31:0] base,
                                            input logic [31:0] span);
        logic [31:0] wide;
        wide = {1'b0, a};
        return (wide >= base) && (wide < (base + span));
    endfunction

endpackage

// File: rtl/sw_host_regs.sv
module sw_host_regs
    import sw_bridge_pkg::*;
#(
    parameter int HOST_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr,
    input  logic [HOST_AW-1:0]   host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    input  logic                 rd_done,
    input  logic [WIDE_W-1:0]    rd_value,
    input  logic                 cmd_accept,
    input  logic [WORD_W-1:0]    status_word,
    output logic [WORD_W-1:0]    data_hi,
    output logic [WORD_W-1:0]    data_lo,
    output logic                 irq_en,
    output logic                 cmd_strobe,
    output logic                 clr_strobe,
    output logic [WORD_W-1:0]    host_rdata
);

    localparam logic [HOST_AW-1:0] A_DHI  = HOST_AW'(OFS_DHI);
    localparam logic [HOST_AW-1:0] A_DLO  = HOST_AW'(OFS_DLO);
    localparam logic [HOST_AW-1:0] A_CMD  = HOST_AW'(OFS_CMD);
    localparam logic [HOST_AW-1:0] A_CLR  = HOST_AW'(OFS_CLR);
    localparam logic [HOST_AW-1:0] A_STAT = HOST_AW'(OFS_STAT);
    localparam logic [HOST_AW-1:0] A_IEN  = HOST_AW'(OFS_IEN);

    logic [WORD_W-1:0] cmd_q;

    assign cmd_strobe = host_wr && (host_addr == A_CMD);
    assign clr_strobe = host_wr && (host_addr == A_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_hi <= '0;
            data_lo <= '0;
        end else if (rd_done) begin
            data_hi <= rd_value[WIDE_W-1:WORD_W];
            data_lo <= rd_value[WORD_W-1:0];
        end else if (host_wr && host_addr == A_DHI) begin
            data_hi <= host_wdata;
        end else if (host_wr && host_addr == A_DLO) begin
            data_lo <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_accept) begin
            cmd_q <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en <= 1'b0;
        end else if (host_wr && host_addr == A_IEN) begin
            irq_en <= host_wdata[0];
        end
    end

    always_comb begin
        case (host_addr)
            A_DHI:   host_rdata = data_hi;
            A_DLO:   host_rdata = data_lo;
            A_CMD:   host_rdata = cmd_q;
            A_STAT:  host_rdata = status_word;
            A_IEN:   host_rdata = {{(WORD_W-1){1'b0}}, irq_en};
            default: host_rdata = '0;
        endcase
    end

    // R8: an accepted command is visible on the next read of the command offset
    AST_CMD_READBACK: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |=> (cmd_q == $past(host_wdata)));  // R8

endmodule

// File: rtl/sw_cmd_decode.sv
module sw_cmd_decode
    import sw_bridge_pkg::*;
#(
    parameter logic [31:0] ENG_BASE = 32'h0007_0000,
    parameter logic [31:0] ENG_SPAN = 32'h0001_0000,
    parameter int          ENG_AW   = 16
) (
    input  logic              cmd_strobe,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              busy,
    output logic              cmd_accept,
    output logic              launch,
    output logic              launch_we,
    output logic [ENG_AW-1:0] launch_addr,
    output logic              range_err,
    output logic              collide
);

    localparam logic [ENG_AW-1:0] BASE_LO = ENG_AW'(ENG_BASE);

    cmd_t cmd;
    logic in_win;

    assign cmd         = cmd_t'(host_wdata);
    assign in_win      = addr_in_window(cmd.addr, ENG_BASE, ENG_SPAN);
    assign cmd_accept  = cmd_strobe && !busy;
    assign collide     = cmd_strobe && busy;
    assign launch      = cmd_accept && in_win;
    assign range_err   = cmd_accept && !in_win;
    assign launch_we   = cmd.write;
    assign launch_addr = ENG_AW'(cmd.addr) - BASE_LO;

    always_comb begin
        AST_DECODE_EXCL: assert ($countones({launch, range_err, collide}) <= 1);  // R6
    end

endmodule

// File: rtl/sw_eng_port.sv
module sw_eng_port
    import sw_bridge_pkg::*;
#(
    parameter int ENG_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_we,
    input  logic [ENG_AW-1:0] launch_addr,
    input  logic [WIDE_W-1:0] launch_wdata,
    input  logic              abort,
    input  logic              eng_ack,
    input  logic [WIDE_W-1:0] eng_rdata,
    output logic              eng_req,
    output logic              eng_we,
    output logic [ENG_AW-1:0] eng_addr,
    output logic [WIDE_W-1:0] eng_wdata,
    output logic              rd_done,
    output logic [WIDE_W-1:0] rd_value,
    output logic              busy
);

    port_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PORT_IDLE;
            eng_we    <= 1'b0;
            eng_addr  <= '0;
            eng_wdata <= '0;
        end else if (abort) begin
            state_q <= PORT_IDLE;
        end else begin
            case (state_q)
                PORT_IDLE: begin
                    if (launch) begin
                        state_q   <= PORT_WAIT;
                        eng_we    <= launch_we;
                        eng_addr  <= launch_addr;
                        eng_wdata <= launch_wdata;
                    end
                end
                PORT_WAIT: begin
                    if (eng_ack) state_q <= PORT_IDLE;
                end
                default: state_q <= PORT_IDLE;
            endcase
        end
    end

    assign busy     = (state_q == PORT_WAIT);
    assign eng_req  = busy;
    assign rd_done  = busy && eng_ack && !abort && !eng_we;
    assign rd_value = eng_rdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack && !abort) |=> eng_req);  // R3

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack && !abort) |=>
            ($stable(eng_addr) && $stable(eng_we) && $stable(eng_wdata)));  // R12

    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (rst)
        abort |=> !eng_req);  // R10

endmodule

// File: rtl/sw_status.sv
module sw_status
    import sw_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              range_err,
    input  logic              collide,
    input  logic              busy,
    output logic [WORD_W-1:0] status_word
);

    err_t err_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_q <= '0;
        end else begin
            if (range_err) err_q.range_bad <= 1'b1;
            if (collide)   err_q.collided  <= 1'b1;
        end
    end

    always_comb begin
        status_word           = '0;
        status_word[ST_BUSY]  = busy;
        status_word[ST_RANGE] = err_q.range_bad;
        status_word[ST_COLL]  = err_q.collided;
        status_word[ST_SUM]   = err_q.range_bad | err_q.collided;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_word[ST_SUM] && !clr) |=> status_word[ST_SUM]);  // R9

    AST_COLL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (collide && !clr) |=> (status_word[ST_COLL] && status_word[ST_SUM]));  // R7

endmodule

// File: rtl/split_word_bridge.sv
module split_word_bridge
    import sw_bridge_pkg::*;
#(
    parameter int          HOST_AW  = 6,
    parameter logic [31:0] ENG_BASE = 32'h0007_0000,
    parameter logic [31:0] ENG_SPAN = 32'h0001_0000,
    parameter int          ENG_AW   = $clog2(ENG_SPAN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               eng_req,
    output logic               eng_we,
    output logic [ENG_AW-1:0]  eng_addr,
    output logic [63:0]        eng_wdata,
    input  logic               eng_ack,
    input  logic [63:0]        eng_rdata,
    output logic               irq
);

    logic [WORD_W-1:0] data_hi, data_lo, status_word;
    logic              irq_en, cmd_strobe, clr_strobe;
    logic              cmd_accept, launch, launch_we, range_err, collide;
    logic [ENG_AW-1:0] launch_addr;
    logic              rd_done, busy;
    logic [WIDE_W-1:0] rd_value;

    sw_host_regs #(.HOST_AW(HOST_AW)) u_regs (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .rd_done(rd_done), .rd_value(rd_value),
        .cmd_accept(cmd_accept), .status_word(status_word),
        .data_hi(data_hi), .data_lo(data_lo), .irq_en(irq_en),
        .cmd_strobe(cmd_strobe), .clr_strobe(clr_strobe),
        .host_rdata(host_rdata)
    );

    sw_cmd_decode #(.ENG_BASE(ENG_BASE), .ENG_SPAN(ENG_SPAN), .ENG_AW(ENG_AW)) u_dec (
        .cmd_strobe(cmd_strobe), .host_wdata(host_wdata), .busy(busy),
        .cmd_accept(cmd_accept), .launch(launch), .launch_we(launch_we),
        .launch_addr(launch_addr), .range_err(range_err), .collide(collide)
    );

    sw_eng_port #(.ENG_AW(ENG_AW)) u_port (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_we(launch_we), .launch_addr(launch_addr),
        .launch_wdata({data_hi, data_lo}), .abort(clr_strobe),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .rd_done(rd_done), .rd_value(rd_value),
        .busy(busy)
    );

    sw_status u_stat (
        .clk(clk), .rst(rst), .clr(clr_strobe),
        .range_err(range_err), .collide(collide), .busy(busy),
        .status_word(status_word)
    );

    assign irq = irq_en & status_word[ST_SUM];

    AST_NO_FWD_BAD: assert property (@(posedge clk) disable iff (rst)
        range_err |=> !eng_req);  // R6

    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_word[ST_SUM] && irq_en));  // R11

    AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (rst)
        (launch && !clr_strobe) |=> (eng_req && status_word[ST_BUSY]));  // R5

endmodule

// File: tb/split_word_bridge_tb.sv
module split_word_bridge_tb;

    localparam int HOST_AW = 6;
    localparam int ENG_AW  = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic               host_wr;
    logic [HOST_AW-1:0] host_addr;
    logic [31:0]        host_wdata;
    logic [31:0]        host_rdata;
    logic               eng_req, eng_we, eng_ack, irq;
    logic [ENG_AW-1:0]  eng_addr;
    logic [63:0]        eng_wdata, eng_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    split_word_bridge u_dut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = HOST_AW'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        host_addr = HOST_AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic ack(input logic [63:0] rv);
        @(negedge clk);
        eng_ack = 1'b1; eng_rdata = rv;
        @(negedge clk);
        eng_ack = 1'b0; eng_rdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        foreach (v[i]) ;
        hread(8'h00, v); check("R1 hi", v, 0);
        hread(8'h04, v); check("R1 lo", v, 0);
        hread(8'h08, v); check("R1 cmd", v, 0);
        hread(8'h1C, v); check("R1 status", v, 0);
        hread(8'h20, v); check("R1 ien", v, 0);
        check("R1 req", eng_req, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_data();
        logic [31:0] v;
        hwrite(8'h00, 32'hCAFE_F00D);
        hwrite(8'h04, 32'h0BAD_BEEF);
        hread(8'h00, v); check("R2 hi readback", v, 32'hCAFE_F00D);
        hread(8'h04, v); check("R2 lo readback", v, 32'h0BAD_BEEF);
        hread(8'h0C, v); check("R2 unmapped", v, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        hwrite(8'h00, 32'hDEAD_BEEF);
        hwrite(8'h04, 32'h0123_4567);
        hwrite(8'h08, 32'h8007_0005);
        check("R3 req", eng_req, 1);
        check("R3 we", eng_we, 1);
        check("R3 addr", eng_addr, 16'h0005);
        check("R3 wdata", eng_wdata, 64'hDEAD_BEEF_0123_4567);
        hread(8'h1C, v); check("R5 busy", v, 32'h1);
        hwrite(8'h00, 32'h5555_AAAA);
        idle(3);
        check("R3 held", eng_req, 1);
        check("R12 wdata stable", eng_wdata, 64'hDEAD_BEEF_0123_4567);
        ack(64'h0);
        check("R3 released", eng_req, 0);
        hread(8'h1C, v); check("R5 idle", v, 0);
        hread(8'h08, v); check("R8 cmd", v, 32'h8007_0005);
    endtask

    task automatic t_read();
        logic [31:0] v;
        hwrite(8'h08, 32'h0007_0009);
        check("R4 req", eng_req, 1);
        check("R4 we", eng_we, 0);
        check("R4 addr", eng_addr, 16'h0009);
        idle(2);
        ack(64'h1122_3344_5566_7788);
        hread(8'h00, v); check("R4 hi", v, 32'h1122_3344);
        hread(8'h04, v); check("R4 lo", v, 32'h5566_7788);
        hread(8'h1C, v); check("R5 done", v, 0);
    endtask

    task automatic t_range();
        logic [31:0] v;
        hwrite(8'h08, 32'h0006_FFFF);
        check("R6 below no req", eng_req, 0);
        hread(8'h1C, v); check("R6 status", v, 32'h8000_0002);
        hread(8'h08, v); check("R8 bad cmd readback", v, 32'h0006_FFFF);
        hwrite(8'h08, 32'h8008_0000);
        check("R6 above no req", eng_req, 0);
        hwrite(8'h08, 32'h0007_FFFF);
        check("R6 top edge req", eng_req, 1);
        check("R6 top edge addr", eng_addr, 16'hFFFF);
        ack(64'h0000_00AA_0000_00BB);
        hread(8'h1C, v); check("R9 sticky", v, 32'h8000_0002);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        check("R11 irq off", irq, 0);
        hwrite(8'h20, 32'h1);
        hread(8'h20, v); check("R11 ien readback", v, 32'h1);
        check("R11 irq on", irq, 1);
        hwrite(8'h18, 32'h0);
        hread(8'h1C, v); check("R10 cleared", v, 0);
        check("R11 irq drop", irq, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        hwrite(8'h08, 32'h0007_0001);
        hwrite(8'h08, 32'h8007_0002);
        hread(8'h1C, v); check("R7 status", v, 32'h8000_0005);
        hread(8'h08, v); check("R7 cmd kept", v, 32'h0007_0001);
        check("R7 addr kept", eng_addr, 16'h0001);
        check("R7 we kept", eng_we, 0);
        check("R11 irq on collide", irq, 1);
        ack(64'hAAAA_BBBB_CCCC_DDDD);
        hread(8'h00, v); check("R7 read completes", v, 32'hAAAA_BBBB);
        hread(8'h1C, v); check("R9 collide sticky", v, 32'h8000_0004);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        hwrite(8'h18, 32'h0);
        hwrite(8'h08, 32'h0007_0003);
        check("R10 req up", eng_req, 1);
        hwrite(8'h18, 32'hFFFF_FFFF);
        check("R10 req dropped", eng_req, 0);
        hread(8'h1C, v); check("R10 status", v, 0);
        ack(64'h1234_5678_9ABC_DEF0);
        hread(8'h00, v); check("R10 late ack hi", v, 32'hAAAA_BBBB);
        hread(8'h04, v); check("R10 late ack lo", v, 32'hCCCC_DDDD);
    endtask

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        eng_ack = 1'b0; eng_rdata = '0;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_data();
        t_write();
        t_read();
        t_range();
        t_irq();
        t_collide();
        t_abort();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule